// File: doc/BRIEF.md
# FIFO Pointer Controller with Rewind and Chained Depth

This block owns the write and read addresses of a FIFO whose storage is an ordinary RAM with one write port and one read port. The write side is driven by an active-low strobe. The controller watches the strobe on every system clock. On the high-to-low transition it decides whether the write may proceed. On the low-to-high transition it issues the RAM write enable at the current write address and then moves that address forward. Reads are requested one word at a time by a single-cycle request. Writes and reads may arrive in any cycle, including the same one. The controller keeps an occupancy count, which drives the full and empty outputs.

A build parameter picks one of two variants. In the stand-alone variant, a low level on the rewind input moves the read address back to location 0 and leaves the write address alone. This lets a stored block be read out again. The hand-over output then reports that more than half the locations are in use. In the chained variant, several controllers form a ring to give a deeper FIFO. The rewind input, sampled while reset is held, marks the device that owns writing and reading first. When a device fills its last location, it gives up the write turn and sends a one-cycle pulse to the next device. When it reads its last location, it gives up the read turn in the same way.

Reset is synchronous and active low. While reset is held, the write strobe must be high and the serial shift clock must be low. Any breach is captured on a fault output.

Top module: `fifo_ptr_ctl`

## Requirements
- R1: One clock edge with rst_n low sets wr_addr and rd_addr to 0, empty to 1 and full to 0. The count also returns to 0, so in the stand-alone variant xo_wr reads 0.
- R2: After reset is released, rst_fault is 1 exactly when the final cycle with rst_n low saw wr_n low or soclk high. It keeps that value until the next reset.
- R3: A write is accepted only if, at the clock edge where wr_n is first seen low, the FIFO is not full and the device holds the write turn. In the following cycle where wr_n is seen high again, ram_we is 1 with wr_addr still at the target location. At that edge wr_addr steps by one.
- R4: When DEPTH words are held, full is 1. A write strobe is then ignored: ram_we stays 0 and wr_addr does not change.
- R5: A cycle with rd_req high advances rd_addr by one if the FIFO is not empty and the device holds the read turn. When the FIFO is empty, rd_req has no effect and empty stays 1.
- R6: If a write commits in the same cycle that a read is accepted, both addresses advance and the occupancy does not change.
- R7: Both addresses wrap from DEPTH-1 to 0.
- R8: In the stand-alone variant, a clock edge with rt_n low sets rd_addr to 0 and leaves wr_addr unchanged. The occupancy becomes the value of wr_addr.
- R9: In the stand-alone variant, xo_wr is 1 exactly when the occupancy exceeds DEPTH/2, and xo_rd is 0.
- R10: In the chained variant, a device that sees rt_n low during reset starts with both the write and the read turn. Any other device starts with neither. After reset, rt_n has no effect.
- R11: In the chained variant, a write commit to location DEPTH-1 gives up the write turn and raises xo_wr for exactly the next cycle. A read of location DEPTH-1 does the same with the read turn and xo_rd. A device without the write turn ignores write strobes.
- R12: In the chained variant, a cycle with xi_wr high grants the write turn, and a cycle with xi_rd high grants the read turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_req | input | 1 | One-cycle request to read the next word |
| rt_n | input | 1 | Rewind (stand-alone) or first-device mark (chained), active low |
| soclk | input | 1 | Serial shift clock level, watched during reset only |
| xi_wr | input | 1 | Write-turn grant pulse from the previous device |
| xi_rd | input | 1 | Read-turn grant pulse from the previous device |
| xo_wr | output | 1 | Write-turn hand-over pulse (chained) or more-than-half flag (stand-alone) |
| xo_rd | output | 1 | Read-turn hand-over pulse (chained), 0 when stand-alone |
| ram_we | output | 1 | RAM write enable at wr_addr |
| wr_addr | output | AW | Write address |
| rd_addr | output | AW | Read address |
| full | output | 1 | All DEPTH locations hold data |
| empty | output | 1 | No location holds data |
| rst_fault | output | 1 | Strobe or shift clock broke the reset rule |

## Verification
The properties assume that wr_n, rd_req and rt_n are already synchronous to clk. They also assume that rewind is used only before the write address has wrapped, because the occupancy taken after a rewind is the write address. The bench drives every input on the falling clock edge. It issues each rewind while fewer than DEPTH words have ever been written since reset. In a chain, it sends the next strobe at least one cycle after a hand-over pulse, so the grant lands before the strobe is sampled.

// File: rtl/ptr_ctl_pkg.sv
package ptr_ctl_pkg;

   typedef enum logic {
      MODE_SOLO  = 1'b0,
      MODE_CHAIN = 1'b1
   } exp_mode_e;

   typedef struct packed {
      logic fall;
      logic rise;
   } strobe_ev_t;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
   import ptr_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe_n,
   output strobe_ev_t ev
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= strobe_n;
   end

   always_comb begin
      ev.fall = prev_q & ~strobe_n;
      ev.rise = ~prev_q & strobe_n;
   end
endmodule

// File: rtl/wrap_ptr.sv
module wrap_ptr #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          rewind,
   output logic [AW-1:0] ptr,
   output logic          at_last
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr <= '0;
      else if (rewind) ptr <= '0;
      else if (step)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   assign at_last = (ptr == LAST);
endmodule

// File: rtl/occupancy.sv
module occupancy #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        inc,
   input  logic        dec,
   input  logic        load,
   input  logic [AW:0] load_val,
   output logic        full,
   output logic        empty,
   output logic        over_half
);
   localparam logic [AW:0] CAP  = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

   logic [AW:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (inc && !dec)  cnt_q <= cnt_q + 1'b1;
      else if (dec && !inc)  cnt_q <= cnt_q - 1'b1;
   end

   assign full      = (cnt_q == CAP);
   assign empty     = (cnt_q == '0);
   assign over_half = (cnt_q > HALF);
endmodule

// File: rtl/hop_token.sv
module hop_token (
   input  logic clk,
   input  logic rst_n,
   input  logic init_own,
   input  logic take,
   input  logic give,
   output logic own,
   output logic hop_pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own       <= init_own;
         hop_pulse <= 1'b0;
      end else begin
         hop_pulse <= give;
         if (take)      own <= 1'b1;
         else if (give) own <= 1'b0;
      end
   end
endmodule

// File: rtl/fifo_ptr_ctl.sv
module fifo_ptr_ctl
   import ptr_ctl_pkg::*;
#(
   parameter int        DEPTH = 16,
   parameter exp_mode_e MODE  = MODE_SOLO,
   localparam int       AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_n,
   input  logic          rd_req,
   input  logic          rt_n,
   input  logic          soclk,
   input  logic          xi_wr,
   input  logic          xi_rd,
   output logic          xo_wr,
   output logic          xo_rd,
   output logic          ram_we,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          full,
   output logic          empty,
   output logic          rst_fault
);
   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("fifo_ptr_ctl: DEPTH must be a power of two and at least 4");
   end

   strobe_ev_t wev;
   logic       armed_q;
   logic       wr_turn, rd_turn;
   logic       rd_go, rewind;
   logic       wr_last, rd_last;
   logic       over_half;
   logic [AW:0] reload;

   strobe_edge u_wedge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (wr_n),
      .ev       (wev)
   );

   // A write is decided on the falling strobe and committed on the rising one.
   always_ff @(posedge clk) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (wev.fall) armed_q <= !full && wr_turn;
      else if (wev.rise) armed_q <= 1'b0;
   end

   assign ram_we = wev.rise & armed_q;
   assign rd_go  = rd_req & ~empty & rd_turn;
   assign reload = {1'b0, wr_addr} + {{AW{1'b0}}, ram_we};

   wrap_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (ram_we),
      .rewind  (1'b0),
      .ptr     (wr_addr),
      .at_last (wr_last)
   );

   wrap_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (rd_go),
      .rewind  (rewind),
      .ptr     (rd_addr),
      .at_last (rd_last)
   );

   occupancy #(.DEPTH(DEPTH)) u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (ram_we),
      .dec       (rd_go),
      .load      (rewind),
      .load_val  (reload),
      .full      (full),
      .empty     (empty),
      .over_half (over_half)
   );

   if (MODE == MODE_CHAIN) begin : g_chain
      assign rewind = 1'b0;

      hop_token u_wtok (
         .clk       (clk),
         .rst_n     (rst_n),
         .init_own  (~rt_n),
         .take      (xi_wr),
         .give      (ram_we & wr_last),
         .own       (wr_turn),
         .hop_pulse (xo_wr)
      );

      hop_token u_rtok (
         .clk       (clk),
         .rst_n     (rst_n),
         .init_own  (~rt_n),
         .take      (xi_rd),
         .give      (rd_go & rd_last),
         .own       (rd_turn),
         .hop_pulse (xo_rd)
      );
   end else begin : g_solo
      assign rewind  = ~rt_n;
      assign wr_turn = 1'b1;
      assign rd_turn = 1'b1;
      assign xo_wr   = over_half;
      assign xo_rd   = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rst_fault <= ~wr_n | soclk;
   end
endmodule

// File: rtl/fifo_ptr_ctl_chk.sv
module fifo_ptr_ctl_chk
   import ptr_ctl_pkg::*;
#(
   parameter int        DEPTH = 16,
   parameter exp_mode_e MODE  = MODE_SOLO,
   localparam int       AW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_req,
   input logic          rt_n,
   input logic          xo_wr,
   input logic          xo_rd,
   input logic          ram_we,
   input logic [AW-1:0] wr_addr,
   input logic [AW-1:0] rd_addr,
   input logic          full,
   input logic          empty
);
   // R1
   reset_home_chk: assert property (@(posedge clk)
      !rst_n |=> (wr_addr == '0 && rd_addr == '0 && empty && !full));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !ram_we);

   // R3
   wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> wr_addr == AW'($past(wr_addr) + 1'b1));

   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_req && rt_n) |=> $stable(rd_addr));

   // R4
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   if (MODE == MODE_SOLO) begin : g_solo_chk
      // R8
      rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rt_n |=> (rd_addr == '0 && $stable(wr_addr)));
      // R9
      no_rd_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !xo_rd);
   end else begin : g_chain_chk
      // R11
      wr_hop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
         xo_wr |=> !xo_wr);
      // R11
      rd_hop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
         xo_rd |=> !xo_rd);
      // R11
      wr_hop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(xo_wr) |-> wr_addr == '0);
   end
endmodule

bind fifo_ptr_ctl fifo_ptr_ctl_chk #(.DEPTH(DEPTH), .MODE(MODE)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_req  (rd_req),
   .rt_n    (rt_n),
   .xo_wr   (xo_wr),
   .xo_rd   (xo_rd),
   .ram_we  (ram_we),
   .wr_addr (wr_addr),
   .rd_addr (rd_addr),
   .full    (full),
   .empty   (empty)
);

// File: tb/fifo_ptr_ctl_test.sv
module fifo_ptr_ctl_test;
   import ptr_ctl_pkg::*;

   localparam int SD = 8;
   localparam int CD = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   int compared   = 0;
   int mismatched = 0;

   // stand-alone device
   logic       rst_n = 1'b0, wr_n = 1'b1, rd_req = 1'b0, rt_n = 1'b1, soclk = 1'b0;
   logic       xo_wr, xo_rd, ram_we, full, empty, rst_fault;
   logic [2:0] wr_addr, rd_addr;

   fifo_ptr_ctl #(.DEPTH(SD), .MODE(MODE_SOLO)) uut (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_req(rd_req), .rt_n(rt_n),
      .soclk(soclk), .xi_wr(1'b0), .xi_rd(1'b0), .xo_wr(xo_wr), .xo_rd(xo_rd),
      .ram_we(ram_we), .wr_addr(wr_addr), .rd_addr(rd_addr), .full(full),
      .empty(empty), .rst_fault(rst_fault));

   // two chained devices in a ring
   logic       crst_n = 1'b0, cwr_n = 1'b1, crd = 1'b0, rt_a = 1'b0;
   logic       a_xw, a_xr, b_xw, b_xr, a_we, b_we, a_f, b_f, a_e, b_e, a_rf, b_rf;
   logic [1:0] a_wa, a_ra, b_wa, b_ra;

   fifo_ptr_ctl #(.DEPTH(CD), .MODE(MODE_CHAIN)) uut_a (
      .clk(clk), .rst_n(crst_n), .wr_n(cwr_n), .rd_req(crd), .rt_n(rt_a),
      .soclk(1'b0), .xi_wr(b_xw), .xi_rd(b_xr), .xo_wr(a_xw), .xo_rd(a_xr),
      .ram_we(a_we), .wr_addr(a_wa), .rd_addr(a_ra), .full(a_f),
      .empty(a_e), .rst_fault(a_rf));

   fifo_ptr_ctl #(.DEPTH(CD), .MODE(MODE_CHAIN)) uut_b (
      .clk(clk), .rst_n(crst_n), .wr_n(cwr_n), .rd_req(crd), .rt_n(1'b1),
      .soclk(1'b0), .xi_wr(a_xw), .xi_rd(a_xr), .xo_wr(b_xw), .xo_rd(b_xr),
      .ram_we(b_we), .wr_addr(b_wa), .rd_addr(b_ra), .full(b_f),
      .empty(b_e), .rst_fault(b_rf));

   typedef struct packed {
      logic [1:0] op;   // 0 write, 1 read, 2 rewind
      logic [2:0] wa;
      logic [2:0] ra;
      logic       f;
      logic       e;
      logic       h;
      logic       we;
   } vec_t;

   localparam vec_t TBL [21] = '{
      '{2'd0, 3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{2'd0, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{2'd1, 3'd2, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd2, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd0, 3'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{2'd0, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{2'd0, 3'd5, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1},
      '{2'd0, 3'd6, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1},
      '{2'd0, 3'd7, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1},
      '{2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1},
      '{2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{2'd1, 3'd0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0},
      '{2'd1, 3'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0},
      '{2'd1, 3'd0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0},
      '{2'd1, 3'd0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd1, 3'd0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd1, 3'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd1, 3'd0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd1, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd1, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd0, 3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1}
   };

   task automatic check(input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // strobe: low for one cycle, high again; commit edge follows the rise
   task automatic solo_write(input logic exp_we, input string tag);
      @(negedge clk) wr_n = 1'b0;
      @(negedge clk) wr_n = 1'b1;
      #1 check({tag, " ram_we"}, int'(ram_we), int'(exp_we));
      @(negedge clk);
   endtask

   task automatic solo_pulse(input logic is_read);
      @(negedge clk) begin
         if (is_read) rd_req = 1'b1;
         else         rt_n   = 1'b0;
      end
      @(negedge clk) begin
         rd_req = 1'b0;
         rt_n   = 1'b1;
      end
   endtask

   task automatic solo_reset(input logic bad_wr, input logic bad_clk);
      @(negedge clk) begin
         rst_n = 1'b0;
         wr_n  = ~bad_wr;
         soclk = bad_clk;
      end
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wr_n  = 1'b1;
      soclk = 1'b0;
      @(negedge clk);
   endtask

   task automatic chain_write();
      @(negedge clk) cwr_n = 1'b0;
      @(negedge clk) cwr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic chain_read();
      @(negedge clk) crd = 1'b1;
      @(negedge clk) crd = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 wr_addr", int'(wr_addr), 0);
      check("R1 rd_addr", int'(rd_addr), 0);
      check("R1 empty", int'(empty), 1);
      check("R1 full", int'(full), 0);
      check("R9 xo_wr at reset", int'(xo_wr), 0);
      check("R2 clean reset", int'(rst_fault), 0);

      foreach (TBL[i]) begin
         string tag;
         case (TBL[i].op)
            2'd0: begin tag = "R3/R4/R7 write"; solo_write(TBL[i].we, tag); end
            2'd1: begin tag = "R5/R7 read";     solo_pulse(1'b1); end
            default: begin tag = "R8 rewind";   solo_pulse(1'b0); end
         endcase
         check({tag, " wr_addr"}, int'(wr_addr), int'(TBL[i].wa));
         check({tag, " rd_addr"}, int'(rd_addr), int'(TBL[i].ra));
         check({tag, " R4 full"}, int'(full), int'(TBL[i].f));
         check({tag, " R5 empty"}, int'(empty), int'(TBL[i].e));
         check({tag, " R9 xo_wr"}, int'(xo_wr), int'(TBL[i].h));
         check({tag, " R9 xo_rd"}, int'(xo_rd), 0);
      end

      // R6: write commit and read in the same cycle; one word held before
      @(negedge clk) wr_n = 1'b0;
      @(negedge clk) begin wr_n = 1'b1; rd_req = 1'b1; end
      @(negedge clk) rd_req = 1'b0;
      check("R6 wr_addr", int'(wr_addr), 2);
      check("R6 rd_addr", int'(rd_addr), 1);
      check("R6 empty", int'(empty), 0);
      solo_pulse(1'b1);
      check("R6 one word left", int'(empty), 1);
      check("R6 rd_addr", int'(rd_addr), 2);

      // R1 R2 reset with strobe low
      solo_reset(1'b1, 1'b0);
      check("R2 strobe low in reset", int'(rst_fault), 1);
      check("R1 wr_addr", int'(wr_addr), 0);
      check("R1 rd_addr", int'(rd_addr), 0);
      check("R1 empty", int'(empty), 1);
      solo_write(1'b1, "R2 fault held");
      check("R2 fault held", int'(rst_fault), 1);
      solo_reset(1'b0, 1'b1);
      check("R2 shift clock high in reset", int'(rst_fault), 1);
      solo_reset(1'b0, 1'b0);
      check("R2 clean again", int'(rst_fault), 0);

      // chained pair: A is first (rt_a low during reset)
      repeat (2) @(negedge clk);
      crst_n = 1'b1;
      @(negedge clk) rt_a = 1'b1;
      check("R10 b has no turn", int'(b_wa), 0);
      for (int k = 0; k < 3; k++) chain_write();
      check("R10 a writes first", int'(a_wa), 3);
      check("R11 b ignores strobes", int'(b_wa), 0);
      @(negedge clk) cwr_n = 1'b0;
      @(negedge clk) cwr_n = 1'b1;
      @(negedge clk);
      check("R7 a wraps", int'(a_wa), 0);
      check("R11 a hop pulse", int'(a_xw), 1);
      check("R4 a full", int'(a_f), 1);
      @(negedge clk);
      check("R11 pulse one cycle", int'(a_xw), 0);
      chain_write();
      check("R12 b took write turn", int'(b_wa), 1);
      check("R11 a idle without turn", int'(a_wa), 0);
      check("R12 b holds a word", int'(b_e), 0);

      chain_read();
      chain_read();
      check("R10 a reads first", int'(a_ra), 2);
      check("R10 b read idle", int'(b_ra), 0);
      @(negedge clk) rt_a = 1'b0;
      @(negedge clk) rt_a = 1'b1;
      check("R10 rt_n ignored in chain", int'(a_ra), 2);
      chain_read();
      chain_read();
      check("R11 a read wraps", int'(a_ra), 0);
      check("R11 a empty", int'(a_e), 1);
      @(negedge clk);
      chain_read();
      check("R12 b took read turn", int'(b_ra), 1);
      check("R12 b empty", int'(b_e), 1);
      check("R11 a stays", int'(a_ra), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule